// File: doc/BRIEF.md
# Blanked Fault Qualifier with Latch-Off Counter

This block sits between a raw comparator flag (an overcurrent or battery-overvoltage detector) and the gate control of a power switch. The flag is first brought into the clock domain by a two-flop synchronizer. It must then stay asserted for a programmable blanking interval before it counts as a real fault. A short glitch restarts the blanking timer and leaves no trace. A qualified fault raises a turn-off request and adds one to a 4-bit event counter. The request stays up until the flag clears.

The sixteenth qualified event does not increment the counter further. It moves the block into a permanent locked-off state, in which the turn-off request is held high whatever the flag does. Only the synchronous reset (power cycling) or the clear strobe (an enable toggle) releases the lock. Each of these also zeroes the counter. One instance per protected quantity is expected, each with its own blanking length in clock cycles (for example about 170 µs for overcurrent and 180 µs for battery overvoltage).

The control is a four-state machine:
- `ST_ARMED`: no synchronized fault is present.
- `ST_BLANKING`: the fault is present and the timer is running.
- `ST_TRIPPED`: the event has been counted and a turn-off is requested.
- `ST_LOCKED`: permanent latch-off.

The transitions are:
- ARMED→BLANKING when the synchronized flag rises.
- BLANKING→ARMED when the flag drops before the timer expires.
- BLANKING→TRIPPED when the timer expires with the flag still high and fewer than 15 events have been stored.
- BLANKING→LOCKED when the timer expires and the count is already 15.
- TRIPPED→ARMED when the flag drops.
- Any state→ARMED on reset or clear.

Top module: `fault_trip_qualifier`

## Requirements
- R1: After reset, `count_o` is 0 and both `trip_o` and `latched_o` are 0.
- R2: With `fault_raw_i` held high from before clock edge 1, `trip_o` is still 0 after edge BLANK_CYCLES+2 and is 1 after edge BLANK_CYCLES+3. This delay is two synchronizer edges, one edge to enter blanking, and BLANK_CYCLES edges of blanking.
- R3: A raw pulse that is high for at most BLANK_CYCLES consecutive edges causes no event: `count_o` is unchanged and `trip_o` stays 0. A pulse of BLANK_CYCLES+1 edges does qualify.
- R4: Each qualified event raises `count_o` by exactly one, as an unsigned binary value. The count never changes by any other step except a clear or a reset to 0.
- R5: One continuous fault episode counts once. `trip_o` stays 1 while the raw flag stays high, and falls 3 edges after the flag drops.
- R6: The 16th qualified event sets `latched_o` to 1 with `trip_o` at 1. `count_o` then holds at its terminal value 15 and does not wrap.
- R7: While latched, fault activity or its absence changes none of `trip_o`, `latched_o` or `count_o`.
- R8: A one-cycle `clr_i` strobe sets `count_o` to 0 and `latched_o` and `trip_o` to 0 after the next edge. The block then counts events again from zero.
- R9: Synchronous reset during operation, including while latched, returns the outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (power cycle) |
| clr_i | input | 1 | Counter-clear and unlock strobe, active high (enable toggle) |
| fault_raw_i | input | 1 | Asynchronous raw comparator fault flag, active high |
| trip_o | output | 1 | Switch turn-off request |
| latched_o | output | 1 | Permanent latch-off flag |
| count_o | output | CNT_W (4) | Number of qualified events stored |

## Verification
The bound checker watches, on every cycle, the invariants that tie the outputs together. A latch always carries a trip request and a count of 15. The latch holds until a clear. The count moves only by single steps, and every fresh trip coincides with one. A clear empties everything on the next edge. The exact blanking latency, the pulse-length boundary between a rejected glitch and a qualified event, the single count per long episode and the drop of the request after the flag clears can only be shown by the bench's timed scenarios. The same holds for the full run of sixteen events into the lock and for reset while locked.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_BLANKING = 2'd1,
        ST_TRIPPED  = 2'd2,
        ST_LOCKED   = 2'd3
    } ftq_state_t;

endpackage

// File: rtl/ftq_sync.sv
module ftq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ftq_blank_timer.sv
module ftq_blank_timer #(
    parameter int CYCLES = 42500
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int TMR_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(CYCLES - 1);

    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)    tmr_q <= '0;
        else if (tmr_q != LAST) tmr_q <= tmr_q + 1'b1;
    end

    assign expired_o = run_i && (tmr_q == LAST);
endmodule

// File: rtl/ftq_event_counter.sv
module ftq_event_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_max_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)                 cnt_q <= '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o  = cnt_q;
    assign at_max_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/fault_trip_qualifier.sv
module fault_trip_qualifier
    import ftq_pkg::*;
#(
    parameter int BLANK_CYCLES = 42500,
    parameter int SYNC_STAGES  = 2,
    parameter int CNT_W        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             fault_raw_i,
    output logic             trip_o,
    output logic             latched_o,
    output logic [CNT_W-1:0] count_o
);
    ftq_state_t state_q, state_d;
    logic       fault_s;
    logic       blank_run;
    logic       blank_done;
    logic       cnt_inc;
    logic       cnt_full;

    ftq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (fault_raw_i),
        .q_o (fault_s)
    );

    assign blank_run = (state_q == ST_BLANKING);

    ftq_blank_timer #(.CYCLES(BLANK_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (blank_run),
        .expired_o (blank_done)
    );

    ftq_event_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr_i),
        .inc_i    (cnt_inc),
        .count_o  (count_o),
        .at_max_o (cnt_full)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst || clr_i) state_q <= ST_ARMED;
        else              state_q <= state_d;
    end

    // Next state and event strobe
    always_comb begin
        state_d = state_q;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (fault_s) state_d = ST_BLANKING;
            end
            ST_BLANKING: begin
                if (!fault_s) begin
                    state_d = ST_ARMED;
                end else if (blank_done) begin
                    if (cnt_full) begin
                        state_d = ST_LOCKED;
                    end else begin
                        state_d = ST_TRIPPED;
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_TRIPPED: begin
                if (!fault_s) state_d = ST_ARMED;
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        trip_o    = 1'b0;
        latched_o = 1'b0;
        unique case (state_q)
            ST_ARMED, ST_BLANKING: begin
                trip_o    = 1'b0;
                latched_o = 1'b0;
            end
            ST_TRIPPED: begin
                trip_o    = 1'b1;
            end
            ST_LOCKED: begin
                trip_o    = 1'b1;
                latched_o = 1'b1;
            end
            default: begin
                trip_o    = 1'b0;
                latched_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ftq_checker.sv
module ftq_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             trip_o,
    input logic             latched_o,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_LATCH_IMPLIES_TRIP: assert property (@(posedge clk) disable iff (rst)
        latched_o |-> trip_o); // R6

    AST_LATCH_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        latched_o |-> (count_o == CNT_MAX)); // R6

    AST_LATCH_ENTRY_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(latched_o) |-> ($past(count_o) == CNT_MAX)); // R6

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (latched_o && !clr_i) |=> (latched_o && $stable(count_o))); // R7

    AST_COUNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (count_o == $past(count_o) ||
                    {1'b0, count_o} == {1'b0, $past(count_o)} + 1'b1)); // R4

    AST_TRIP_COUNTS_ONCE: assert property (@(posedge clk) disable iff (rst)
        ($rose(trip_o) && !latched_o) |->
            ({1'b0, count_o} == {1'b0, $past(count_o)} + 1'b1)); // R4

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_o == '0 && !latched_o && !trip_o)); // R8
endmodule

bind fault_trip_qualifier ftq_checker #(.CNT_W(CNT_W)) u_ftq_checker (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_i),
    .trip_o    (trip_o),
    .latched_o (latched_o),
    .count_o   (count_o)
);

// File: tb/fault_trip_qualifier_tb_top.sv
`timescale 1ns/1ps
module fault_trip_qualifier_tb_top;
    localparam int N     = 12;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr_i = 1'b0;
    logic             fault_raw_i = 1'b0;
    logic             trip_o;
    logic             latched_o;
    logic [CNT_W-1:0] count_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fault_trip_qualifier #(.BLANK_CYCLES(N), .SYNC_STAGES(2), .CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (clr_i),
        .fault_raw_i (fault_raw_i),
        .trip_o      (trip_o),
        .latched_o   (latched_o),
        .count_o     (count_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic t, input logic l, input logic [3:0] c);
        check({req, " trip"}, {7'd0, trip_o}, {7'd0, t});
        check({req, " latched"}, {7'd0, latched_o}, {7'd0, l});
        check({req, " count"}, {4'd0, count_o}, {4'd0, c});
    endtask

    // one full qualified episode, returns to armed
    task automatic fire_event();
        fault_raw_i = 1'b1;
        tick(N + 3);
        fault_raw_i = 1'b0;
        tick(3);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1 after reset", 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_latency();
        fault_raw_i = 1'b1;
        tick(N + 2);
        check("R2 before blank end", {7'd0, trip_o}, 8'd0);
        tick(1);
        check("R2 at blank end", {7'd0, trip_o}, 8'd1);
        check("R4 first event", {4'd0, count_o}, 8'd1);
        tick(20);
        check("R5 long episode trip held", {7'd0, trip_o}, 8'd1);
        check("R5 long episode counted once", {4'd0, count_o}, 8'd1);
        fault_raw_i = 1'b0;
        tick(2);
        check("R5 trip held 2 edges after drop", {7'd0, trip_o}, 8'd1);
        tick(1);
        check("R5 trip low 3 edges after drop", {7'd0, trip_o}, 8'd0);
    endtask

    task automatic t_glitch();
        logic seen = 1'b0;
        fault_raw_i = 1'b1;
        for (int i = 0; i < N; i++) begin
            tick(1);
            if (trip_o) seen = 1'b1;
        end
        fault_raw_i = 1'b0;
        for (int i = 0; i < N + 6; i++) begin
            tick(1);
            if (trip_o) seen = 1'b1;
        end
        check("R3 N-edge pulse no trip", {7'd0, seen}, 8'd0);
        check("R3 N-edge pulse no count", {4'd0, count_o}, 8'd1);
        fault_raw_i = 1'b1;
        tick(N + 1);
        fault_raw_i = 1'b0;
        tick(2);
        check("R3 N+1-edge pulse trips", {7'd0, trip_o}, 8'd1);
        check("R3 N+1-edge pulse counts", {4'd0, count_o}, 8'd2);
        tick(1);
        check("R5 short episode release", {7'd0, trip_o}, 8'd0);
    endtask

    task automatic t_to_latch();
        for (int k = 3; k <= 15; k++) fire_event();
        check_all("R4 fifteen events", 1'b0, 1'b0, 4'd15);
        fault_raw_i = 1'b1;
        tick(N + 3);
        check_all("R6 sixteenth event locks", 1'b1, 1'b1, 4'd15);
    endtask

    task automatic t_locked_hold();
        fault_raw_i = 1'b0;
        tick(10);
        check_all("R7 locked after flag drop", 1'b1, 1'b1, 4'd15);
        for (int k = 0; k < 3; k++) begin
            fault_raw_i = 1'b1;
            tick(N + 5);
            fault_raw_i = 1'b0;
            tick(5);
        end
        check_all("R7 locked ignores new faults", 1'b1, 1'b1, 4'd15);
    endtask

    task automatic t_clear();
        clr_i = 1'b1;
        tick(1);
        clr_i = 1'b0;
        check_all("R8 clear unlocks", 1'b0, 1'b0, 4'd0);
        fire_event();
        check_all("R8 counting resumes", 1'b0, 1'b0, 4'd1);
        fire_event();
        fire_event();
        clr_i = 1'b1;
        tick(1);
        clr_i = 1'b0;
        check_all("R8 clear from unlocked count", 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_reset_locked();
        for (int k = 0; k < 16; k++) fire_event();
        check_all("R6 relock after sixteen", 1'b1, 1'b1, 4'd15);
        do_reset();
        check_all("R9 reset releases lock", 1'b0, 1'b0, 4'd0);
        fire_event();
        fire_event();
        do_reset();
        check_all("R9 reset mid count", 1'b0, 1'b0, 4'd0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_latency();
        t_glitch();
        t_to_latch();
        t_locked_hold();
        t_clear();
        t_reset_locked();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule